// File: doc/BRIEF.md
# Write-Through First-Level Read Cache

This block is a small direct-mapped cache that sits between one user access port and one port of a larger shared second-level cache. Reads whose line is resident are answered combinationally in the cycle they are presented, with no trip through the downstream port. A read that misses fetches the whole line from downstream, one word per beat, while the user side is held. Once the line is in, the requested word is returned on the following cycle.

Writes are never held in this cache. Each write passes to the downstream port unchanged, with the same address and data, and the user sees it accepted in the same cycle the downstream port accepts it. If the written word belongs to a resident line, the local copy is also updated. Later reads therefore always see the latest value. A flush input drops every line in one cycle.

The cache is direct mapped. For a word address, the low bits select the word within a line, the next bits select the line slot, and the remaining bits form the stored tag. The line length in words is a parameter and must equal the downstream line length. The number of slots is also a parameter. Both are powers of two. The controller has three states. `ST_IDLE` serves hits and writes. A read miss moves it to `ST_FILL_REQ`, where it holds the line request until the request is accepted. It then moves to `ST_FILL_BEATS`, where it collects the line words. After the last word it returns to `ST_IDLE`.

Top module: `l1_rd_cache`

## Requirements
- R1: After reset, `rsp_valid`, `req_ready` and `dn_req_valid` are low while no request is presented, and every line slot is empty, so the first read of any address misses.
- R2: A read whose line is resident raises `rsp_valid` and `req_ready` in the same cycle it is presented, returns the stored word, and raises no downstream request.
- R3: A read miss issues exactly one downstream request with `dn_req_write` low, at the line-aligned word address (word-offset bits zero). Address and kind stay stable until `dn_req_ready` is seen.
- R4: During a fill, the user port is stalled (`req_ready` and `rsp_valid` low). Downstream beats carry words 0 to WORDS-1 of the line in order. The word is returned in the cycle after the last beat, so a miss takes at least WORDS+2 cycles.
- R5: A write is forwarded with `dn_req_write` high and the user's address and data unchanged. `req_ready` follows `dn_req_ready`, and a write never raises `rsp_valid`.
- R6: A write that hits a resident line updates that word locally, so a following read of it hits and returns the new data.
- R7: A write that misses allocates no line, so a following read of that address misses.
- R8: A cycle with `flush` high empties every slot, so the next read of any address misses.
- R9: The slot is the line address modulo LINES. Two lines that share a slot but differ in tag evict each other.
- R10: Every read returns the most recent value written to its address, or the downstream value if the address was never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | User request present, held until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | User word address |
| req_wdata | input | DATA_W | User write data |
| req_ready | output | 1 | User request accepted this cycle |
| rsp_valid | output | 1 | Read data valid this cycle |
| rsp_rdata | output | DATA_W | Read data |
| dn_req_valid | output | 1 | Downstream request present |
| dn_req_ready | input | 1 | Downstream accepts request |
| dn_req_write | output | 1 | Downstream request kind, 1 = write |
| dn_req_addr | output | ADDR_W | Downstream word address (line base for fills) |
| dn_req_wdata | output | DATA_W | Downstream write data |
| dn_rsp_valid | input | 1 | Fill beat valid |
| dn_rsp_data | input | DATA_W | Fill beat word |

## Verification
A read hit is due in the very cycle the request is driven, so the bench drives at the falling edge and samples before the next rising edge. It expects `rsp_valid` at that first sample exactly when its own slot and tag model predicts a hit. A miss is due one cycle after the final fill beat. The bench counts sample points until `rsp_valid`, requires at least WORDS+2 of them, and checks that `req_ready` stayed low throughout. Writes are complete at the first sample where the downstream model's random ready is high. The downstream model checks each accepted request at that same sample and applies writes to its memory before the next operation begins.

// File: rtl/l1c_pkg.sv
package l1c_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_FILL_REQ   = 2'd1,
        ST_FILL_BEATS = 2'd2
    } l1c_state_e;

endpackage

// File: rtl/l1c_tag_array.sv
module l1c_tag_array #(
    parameter int LINES = 8,
    parameter int TAG_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    output logic                     rd_valid,
    output logic [TAG_W-1:0]         rd_tag,
    input  logic                     clr_en,
    input  logic                     set_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic [TAG_W-1:0]         set_tag
);
    localparam int IDX_W = $clog2(LINES);

    logic [LINES-1:0] slot_valid;
    logic [TAG_W-1:0] slot_tag [LINES];

    for (genvar s = 0; s < LINES; s++) begin : g_slot
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        logic             sel;

        assign sel = (wr_idx == IDX_W'(s));

        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                v_q <= 1'b0;
            end else if (sel && set_en) begin
                v_q <= 1'b1;
            end else if (sel && clr_en) begin
                v_q <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (sel && set_en) begin
                t_q <= set_tag;
            end
        end

        assign slot_valid[s] = v_q;
        assign slot_tag[s]   = t_q;
    end

    assign rd_valid = slot_valid[rd_idx];
    assign rd_tag   = slot_tag[rd_idx];

endmodule

// File: rtl/l1c_data_array.sv
module l1c_data_array #(
    parameter int LINES  = 8,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic [$clog2(WORDS)-1:0] wr_off,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    input  logic [$clog2(WORDS)-1:0] rd_off,
    output logic [DATA_W-1:0]        rd_data
);
    localparam int IDX_W = $clog2(LINES);

    logic [DATA_W-1:0] line_word [LINES];

    for (genvar s = 0; s < LINES; s++) begin : g_line
        logic [DATA_W-1:0] words_q [WORDS];

        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(s)) begin
                words_q[wr_off] <= wr_data;
            end
        end

        assign line_word[s] = words_q[rd_off];
    end

    assign rd_data = line_word[rd_idx];

endmodule

// File: rtl/l1c_ctrl.sv
module l1c_ctrl
    import l1c_pkg::*;
#(
    parameter int WORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic                     hit,
    input  logic                     dn_req_ready,
    input  logic                     dn_rsp_valid,
    output logic                     req_ready,
    output logic                     rsp_valid,
    output logic                     dn_req_valid,
    output logic                     dn_req_write,
    output logic                     miss_inval,
    output logic                     fill_we,
    output logic                     fill_done,
    output logic                     wr_hit_we,
    output logic [$clog2(WORDS)-1:0] fill_off
);
    localparam int OFF_W = $clog2(WORDS);
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

    l1c_state_e       state_q, state_d;
    logic [OFF_W-1:0] beat_q;

    // state register and beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FILL_REQ) begin
                beat_q <= '0;
            end else if (state_q == ST_FILL_BEATS && dn_rsp_valid) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && !req_write && !hit) begin
                    state_d = ST_FILL_REQ;
                end
            end
            ST_FILL_REQ: begin
                if (dn_req_ready) begin
                    state_d = ST_FILL_BEATS;
                end
            end
            ST_FILL_BEATS: begin
                if (dn_rsp_valid && beat_q == LAST_BEAT) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        rsp_valid    = 1'b0;
        dn_req_valid = 1'b0;
        dn_req_write = 1'b0;
        miss_inval   = 1'b0;
        fill_we      = 1'b0;
        fill_done    = 1'b0;
        wr_hit_we    = 1'b0;
        fill_off     = beat_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && req_write) begin
                    dn_req_valid = 1'b1;
                    dn_req_write = 1'b1;
                    req_ready    = dn_req_ready;
                    wr_hit_we    = hit && dn_req_ready;
                end else if (req_valid && hit) begin
                    rsp_valid = 1'b1;
                    req_ready = 1'b1;
                end else if (req_valid) begin
                    miss_inval = 1'b1;
                end
            end
            ST_FILL_REQ: begin
                dn_req_valid = 1'b1;
            end
            ST_FILL_BEATS: begin
                fill_we   = dn_rsp_valid;
                fill_done = dn_rsp_valid && (beat_q == LAST_BEAT);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/l1_rd_cache.sv
module l1_rd_cache #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int LINES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dn_req_valid,
    input  logic              dn_req_ready,
    output logic              dn_req_write,
    output logic [ADDR_W-1:0] dn_req_addr,
    output logic [DATA_W-1:0] dn_req_wdata,
    input  logic              dn_rsp_valid,
    input  logic [DATA_W-1:0] dn_rsp_data
);
    localparam int OFF_W = $clog2(WORDS);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    logic [OFF_W-1:0] req_off;
    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic             slot_valid;
    logic [TAG_W-1:0] slot_tag;
    logic             hit;
    logic             miss_inval, fill_we, fill_done, wr_hit_we;
    logic [OFF_W-1:0] fill_off;
    logic             data_we;
    logic [OFF_W-1:0] data_off;
    logic [DATA_W-1:0] data_in;

    assign req_off = req_addr[OFF_W-1:0];
    assign req_idx = req_addr[OFF_W +: IDX_W];
    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign hit     = slot_valid && (slot_tag == req_tag);

    l1c_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .rd_idx   (req_idx),
        .rd_valid (slot_valid),
        .rd_tag   (slot_tag),
        .clr_en   (miss_inval),
        .set_en   (fill_done),
        .wr_idx   (req_idx),
        .set_tag  (req_tag)
    );

    assign data_we  = fill_we || wr_hit_we;
    assign data_off = fill_we ? fill_off : req_off;
    assign data_in  = fill_we ? dn_rsp_data : req_wdata;

    l1c_data_array #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .wr_en   (data_we),
        .wr_idx  (req_idx),
        .wr_off  (data_off),
        .wr_data (data_in),
        .rd_idx  (req_idx),
        .rd_off  (req_off),
        .rd_data (rsp_rdata)
    );

    l1c_ctrl #(.WORDS(WORDS)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .hit          (hit),
        .dn_req_ready (dn_req_ready),
        .dn_rsp_valid (dn_rsp_valid),
        .req_ready    (req_ready),
        .rsp_valid    (rsp_valid),
        .dn_req_valid (dn_req_valid),
        .dn_req_write (dn_req_write),
        .miss_inval   (miss_inval),
        .fill_we      (fill_we),
        .fill_done    (fill_done),
        .wr_hit_we    (wr_hit_we),
        .fill_off     (fill_off)
    );

    assign dn_req_addr  = dn_req_write ? req_addr
                                       : {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign dn_req_wdata = req_wdata;

endmodule

// File: rtl/l1c_checker.sv
module l1c_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              dn_req_valid,
    input logic              dn_req_ready,
    input logic              dn_req_write,
    input logic [ADDR_W-1:0] dn_req_addr
);
    // R2
    hit_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready && !dn_req_valid);

    // R3
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid && !dn_req_write && !dn_req_ready
        |=> dn_req_valid && !dn_req_write && $stable(dn_req_addr));

    // R4
    fill_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid && !dn_req_write && dn_req_ready |=> !rsp_valid && !req_ready);

    // R5
    write_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write |-> !rsp_valid);

    // R8
    flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) && req_valid && !req_write |-> !rsp_valid);

endmodule

bind l1_rd_cache l1c_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .dn_req_valid (dn_req_valid),
    .dn_req_ready (dn_req_ready),
    .dn_req_write (dn_req_write),
    .dn_req_addr  (dn_req_addr)
);

// File: tb/tb_l1_rd_cache.sv
`timescale 1ns/1ps
module tb_l1_rd_cache;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int WORDS  = 4;
    localparam int LINES  = 8;
    localparam int OFF_W  = 2;
    localparam int IDX_W  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic dn_req_valid, dn_req_write;
    logic dn_req_ready = 1'b0;
    logic [ADDR_W-1:0] dn_req_addr;
    logic [DATA_W-1:0] dn_req_wdata;
    logic dn_rsp_valid = 1'b0;
    logic [DATA_W-1:0] dn_rsp_data = '0;

    always #4 clk = ~clk;

    l1_rd_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
        .dn_req_write(dn_req_write), .dn_req_addr(dn_req_addr), .dn_req_wdata(dn_req_wdata),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_data(dn_rsp_data)
    );

    int n_chk = 0;
    int n_err = 0;
    int fills = 0;
    logic [DATA_W-1:0] mem [256];
    bit mv [LINES];
    int mt [LINES];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int slot_of(input logic [ADDR_W-1:0] a);
        return int'(a >> OFF_W) % LINES;
    endfunction

    function automatic int tag_of(input logic [ADDR_W-1:0] a);
        return int'(a >> (OFF_W + IDX_W));
    endfunction

    function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    endfunction

    // downstream second-level model
    bit hs_w = 0, hs_r = 0, beat_taken = 0;
    logic [ADDR_W-1:0] hs_addr;
    logic [DATA_W-1:0] hs_data;
    logic [ADDR_W-1:0] pbase = '0;
    int pidx = 0, pend = 0;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = (i * 32'h0100_0193) ^ 32'hA5A5_0000;
        forever begin
            @(negedge clk);
            if (hs_w) mem[hs_addr] = hs_data;
            if (hs_r) begin pbase = hs_addr; pidx = 0; pend = WORDS; end
            if (beat_taken) begin pidx++; pend--; end
            dn_req_ready = ($urandom % 2) == 0;
            dn_rsp_valid = (pend > 0) && (($urandom % 3) != 0);
            dn_rsp_data  = mem[pbase + ADDR_W'(pidx)];
            #3;
            hs_w = rst_n && dn_req_valid && dn_req_ready && dn_req_write;
            hs_r = rst_n && dn_req_valid && dn_req_ready && !dn_req_write;
            hs_addr = dn_req_addr;
            hs_data = dn_req_wdata;
            beat_taken = dn_rsp_valid;
            if (hs_r) begin
                fills++;
                chk(dn_req_addr == line_base(req_addr), "R3", "fill address",
                    32'(dn_req_addr), 32'(line_base(req_addr)));
            end
            if (hs_w) begin
                chk(dn_req_addr == req_addr && dn_req_wdata == req_wdata, "R5",
                    "forwarded write", dn_req_wdata, req_wdata);
            end
        end
    end

    task automatic do_read(input logic [ADDR_W-1:0] a, input string tag);
        int s = slot_of(a);
        int t = tag_of(a);
        bit exp_hit = mv[s] && (mt[s] == t);
        int cyc = 0;
        int f0;
        bit stall_ok = 1;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        f0 = fills;
        forever begin
            #3;
            if (rsp_valid) break;
            if (req_ready) stall_ok = 0;
            cyc++;
            if (cyc > 2000) break;
            @(negedge clk);
        end
        // R10: value always matches the latest written data
        chk(rsp_rdata == mem[a], tag, "read data", rsp_rdata, mem[a]);
        if (exp_hit) begin
            // R2: hit answered in the first cycle with no fill
            chk(cyc == 0 && fills == f0, tag, "hit timing (R2)", 32'(cyc), 32'd0);
        end else begin
            // R3/R4: one fill, stalled, at least WORDS+2 cycles
            chk(fills == f0 + 1, tag, "fill count (R3)", 32'(fills - f0), 32'd1);
            chk(stall_ok && cyc >= WORDS + 2, tag, "miss stall (R4)", 32'(cyc), 32'(WORDS + 2));
        end
        mv[s] = 1'b1; mt[s] = t;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input string tag);
        bit rsp_seen = 0;
        int cyc = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        forever begin
            #3;
            if (rsp_valid) rsp_seen = 1;
            if (req_ready) break;
            cyc++;
            if (cyc > 2000) break;
            @(negedge clk);
        end
        chk(!rsp_seen && dn_req_ready, tag, "write accept (R5)", 32'(rsp_seen), 32'd0);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < LINES; i++) mv[i] = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < LINES; i++) begin mv[i] = 1'b0; mt[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        // R1: idle outputs after reset
        chk(!rsp_valid && !req_ready && !dn_req_valid, "R1", "idle outputs",
            {29'd0, rsp_valid, req_ready, dn_req_valid}, 32'd0);

        do_read(8'h10, "R1");
        do_read(8'h11, "R2");
        do_read(8'h13, "R2");
        do_write(8'h12, 32'hDEAD_0012, "R5");
        do_read(8'h12, "R6");
        do_write(8'h45, 32'hBEEF_0045, "R7");
        do_read(8'h45, "R7");
        do_read(8'h30, "R9");
        do_read(8'h10, "R9");
        do_flush();
        do_read(8'h11, "R8");

        for (int k = 0; k < 400; k++) begin
            int r = $urandom % 100;
            logic [ADDR_W-1:0] a = ADDR_W'($urandom % 128);
            if (r < 65)      do_read(a, "R10");
            else if (r < 95) do_write(a, $urandom, "R10");
            else             do_flush();
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule